// File: doc/BRIEF.md
# Receive Chunk Substitution Tap

This block sits on the receive path between a serial line and an HDLC receiver. Line bits are shifted into a 32-bit register whenever a bit is valid, the current time slot is active and the receiver is enabled. Each time a programmable number of bytes (one, two or four) has arrived, the complete shift register is copied into a read register. Two read copies are kept, one for a DSP and one for a host. A single write register then sits between that read data and the HDLC receiver.

The write register takes the read data one cycle after each chunk by default. Whichever processor owns the register can overwrite it before the next chunk completes. In that way it can substitute pre-processed data. When the next chunk completes, the write register contents are handed to the HDLC receiver. After a receiver reset, the first chunk only primes the pipeline and is not forwarded. A transparent mode aligns the start of reception to the leading edge of the active time slot. A bypass mode forwards line data straight to the HDLC receiver. In bypass mode the register loads and interrupts stay active for observation.

Top module: `rx_prep_tap`

## Requirements
- R1: A bit is accepted only in a cycle with `bit_vld`, `slot_act` and `rx_en` all high and `rx_rst` low. It enters the shift register at bit 0 while older bits move up one place. A chunk completes on the 8th, 16th or 32nd accepted bit for `cfg_chunk` 00, 01 and 10/11 respectively.
- R2: On the clock edge that accepts the last bit of a chunk, both `dsp_rdata` and `host_rdata` take the full 32-bit shift contents including that bit. In any mode other than bypass, `hdlc_data` takes the write-register value on that same edge and `hdlc_vld` is high for exactly one cycle. `hdlc_vld` is never high at any other time.
- R3: One edge after a chunk completes, the write register takes the read data unless an owner write occurs, and `dsp_stat` and `host_stat` are both set.
- R4: `cfg_owner` = 0 gives write access to the DSP port and 1 gives it to the host port. A write from the other port has no effect on what is later forwarded. An owner write on the same edge as the default copy wins.
- R5: After `rx_rst` or the asynchronous reset, the first completed chunk in a non-bypass mode produces no `hdlc_vld`, but it still loads the read registers and sets the status. The second chunk forwards the data of the first.
- R6: With `cfg_transparent` = 1, reception starts only on a valid bit whose `slot_act` is high when the previous valid bit had it low. If the enable is raised partway through the slot, nothing is taken until the slot begins in the next frame.
- R7: Slot-edge tracking runs while the receiver is disabled. An enable raised before the slot begins therefore starts reception in that slot of the same frame.
- R8: With `cfg_mode` = 00 (bypass), `hdlc_data` carries the completed shift contents with `hdlc_vld` on the completion edge, including the first chunk after a reset. Read registers and status still load.
- R9: Each status bit stays set until its own side pulses its clear input. A set on the same edge wins over the clear. The side's interrupt output equals status AND NOT mask, and the mask never alters the status.
- R10: After reset, `hdlc_vld`, both read registers, both status bits and both interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_rst | input | 1 | Synchronous receiver reset |
| rx_en | input | 1 | Receiver enable |
| cfg_mode | input | 2 | 00 bypass, other codes pre-processing |
| cfg_chunk | input | 2 | Chunk size: 00 one byte, 01 two, 10/11 four |
| cfg_transparent | input | 1 | Slot-aligned start |
| cfg_owner | input | 1 | Write-register owner: 0 DSP, 1 host |
| line_bit | input | 1 | Serial line data |
| bit_vld | input | 1 | Line bit valid this cycle |
| slot_act | input | 1 | Current bit lies in the selected time slot |
| hdlc_data | output | 32 | Chunk handed to the HDLC receiver |
| hdlc_vld | output | 1 | One-cycle strobe for hdlc_data |
| dsp_we | input | 1 | DSP write strobe |
| dsp_wdata | input | 32 | DSP write data |
| dsp_clr | input | 1 | DSP status clear |
| dsp_mask | input | 1 | DSP interrupt mask |
| dsp_rdata | output | 32 | DSP read copy |
| dsp_stat | output | 1 | DSP buffer-full status |
| dsp_irq | output | 1 | DSP interrupt |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_clr | input | 1 | Host status clear |
| host_mask | input | 1 | Host interrupt mask |
| host_rdata | output | 32 | Host read copy |
| host_stat | output | 1 | Host buffer-full status |
| host_irq | output | 1 | Host interrupt |

## Verification
The assertions assume that `cfg_chunk`, `cfg_mode` and `cfg_transparent` only change while no chunk is partly shifted, or across a receiver reset. They also assume that the slot indication is meaningful only on cycles carrying a valid bit. The stimulus changes configuration only between chunks, after a completed chunk or around an `rx_rst` pulse. It drives `slot_act` as a fixed window of eight bits in a 32-bit frame, or holds it high for plain chunk traffic. Processor writes are issued only in idle cycles between chunks, so the one-chunk substitution window is never exceeded.

// File: rtl/rxtap_pkg.sv
package rxtap_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_PRE_A  = 2'b01,
    MODE_PRE_B  = 2'b10,
    MODE_PRE_C  = 2'b11
  } tap_mode_e;

  localparam int unsigned SIDES = 2;  // index 0 DSP, index 1 host
endpackage

// File: rtl/rxtap_slot_gate.sv
module rxtap_slot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_rst,
  input  logic rx_en,
  input  logic transparent,
  input  logic bit_vld,
  input  logic slot_act,
  output logic accept
);
  logic slot_prev_q, slot_prev_d;
  logic run_q, run_d;
  logic slot_start, gate_open;

  // slot edge tracking is independent of the enable
  always_comb begin
    slot_start  = bit_vld & slot_act & ~slot_prev_q;
    gate_open   = run_q | ~transparent | slot_start;
    accept      = bit_vld & slot_act & rx_en & ~rx_rst & gate_open;
    slot_prev_d = bit_vld ? slot_act : slot_prev_q;
    if (rx_rst || !rx_en) begin
      run_d = 1'b0;
    end else if (accept) begin
      run_d = 1'b1;
    end else begin
      run_d = run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_prev_q <= 1'b0;
      run_q       <= 1'b0;
    end else begin
      slot_prev_q <= slot_prev_d;
      run_q       <= run_d;
    end
  end

  AST_ALIGNED_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) && $past(transparent) |-> $past(slot_act && !slot_prev_q)); // R6
endmodule

// File: rtl/rxtap_shifter.sv
module rxtap_shifter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_rst,
  input  logic              accept,
  input  logic              line_bit,
  input  logic [1:0]        chunk_sel,
  output logic [DATA_W-1:0] sr_shift,
  output logic              chunk_done
);
  localparam int unsigned CNT_W   = $clog2(DATA_W);
  localparam int unsigned MAX_LOG = $clog2(DATA_W / 8);

  logic [CNT_W-1:0]  cnt_q, cnt_d, last_idx;
  logic [DATA_W-1:0] sr_q, sr_d;

  always_comb begin
    if (int'(chunk_sel) >= int'(MAX_LOG)) begin
      last_idx = CNT_W'(DATA_W - 1);
    end else begin
      last_idx = CNT_W'((8 << chunk_sel) - 1);
    end
    sr_shift   = {sr_q[DATA_W-2:0], line_bit};
    chunk_done = accept & (cnt_q >= last_idx);
    sr_d       = sr_q;
    cnt_d      = cnt_q;
    if (rx_rst) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (accept) begin
      sr_d  = sr_shift;
      cnt_d = chunk_done ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !chunk_done && !rx_rst |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R1
endmodule

// File: rtl/rxtap_side.sv
module rxtap_side #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              stat_set,
  input  logic              clr,
  input  logic              mask,
  output logic [DATA_W-1:0] rd_q,
  output logic              stat_q,
  output logic              irq
);
  logic [DATA_W-1:0] rd_d;
  logic              stat_d;

  always_comb begin
    rd_d   = rd_q;
    stat_d = stat_q;
    if (rx_rst) begin
      rd_d   = '0;
      stat_d = 1'b0;
    end else begin
      if (load) begin
        rd_d = load_data;
      end
      if (stat_set) begin
        stat_d = 1'b1;
      end else if (clr) begin
        stat_d = 1'b0;
      end
    end
    irq = stat_q & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      stat_q <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      stat_q <= stat_d;
    end
  end

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q && !clr && !rx_rst |=> stat_q); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !rx_rst |=> $stable(rd_q)); // R2
endmodule

// File: rtl/rx_prep_tap.sv
module rx_prep_tap #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_rst,
  input  logic              rx_en,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_chunk,
  input  logic              cfg_transparent,
  input  logic              cfg_owner,
  input  logic              line_bit,
  input  logic              bit_vld,
  input  logic              slot_act,
  output logic [DATA_W-1:0] hdlc_data,
  output logic              hdlc_vld,
  input  logic              dsp_we,
  input  logic [DATA_W-1:0] dsp_wdata,
  input  logic              dsp_clr,
  input  logic              dsp_mask,
  output logic [DATA_W-1:0] dsp_rdata,
  output logic              dsp_stat,
  output logic              dsp_irq,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_clr,
  input  logic              host_mask,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_stat,
  output logic              host_irq
);
  import rxtap_pkg::*;

  logic              accept, chunk_done, bypass;
  logic [DATA_W-1:0] sr_shift;
  logic [SIDES-1:0]  clr_v, mask_v, stat_v, irq_v;
  logic [DATA_W-1:0] rd_v [SIDES];

  logic              copy_pend_q, copy_pend_d;
  logic              primed_q, primed_d;
  logic [DATA_W-1:0] wr_q, wr_d, wr_data;
  logic              wr_sel;
  logic [DATA_W-1:0] out_q, out_d;
  logic              vld_q, vld_d;

  rxtap_slot_gate i_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_rst      (rx_rst),
    .rx_en       (rx_en),
    .transparent (cfg_transparent),
    .bit_vld     (bit_vld),
    .slot_act    (slot_act),
    .accept      (accept)
  );

  rxtap_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_rst     (rx_rst),
    .accept     (accept),
    .line_bit   (line_bit),
    .chunk_sel  (cfg_chunk),
    .sr_shift   (sr_shift),
    .chunk_done (chunk_done)
  );

  assign clr_v  = {host_clr, dsp_clr};
  assign mask_v = {host_mask, dsp_mask};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    rxtap_side #(.DATA_W(DATA_W)) i_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_rst    (rx_rst),
      .load      (chunk_done),
      .load_data (sr_shift),
      .stat_set  (copy_pend_q),
      .clr       (clr_v[s]),
      .mask      (mask_v[s]),
      .rd_q      (rd_v[s]),
      .stat_q    (stat_v[s]),
      .irq       (irq_v[s])
    );
  end

  always_comb begin
    bypass  = (cfg_mode == MODE_BYPASS);
    wr_sel  = cfg_owner ? host_we : dsp_we;
    wr_data = cfg_owner ? host_wdata : dsp_wdata;

    copy_pend_d = ~rx_rst & chunk_done;
    primed_d    = rx_rst ? 1'b0 : (primed_q | chunk_done);

    // owner write beats the default copy
    if (rx_rst) begin
      wr_d = '0;
    end else if (wr_sel) begin
      wr_d = wr_data;
    end else if (copy_pend_q) begin
      wr_d = rd_v[0];
    end else begin
      wr_d = wr_q;
    end

    vld_d = ~rx_rst & chunk_done & (bypass | primed_q);
    out_d = out_q;
    if (chunk_done) begin
      out_d = bypass ? sr_shift : wr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_pend_q <= 1'b0;
      primed_q    <= 1'b0;
      wr_q        <= '0;
      out_q       <= '0;
      vld_q       <= 1'b0;
    end else begin
      copy_pend_q <= copy_pend_d;
      primed_q    <= primed_d;
      wr_q        <= wr_d;
      out_q       <= out_d;
      vld_q       <= vld_d;
    end
  end

  assign hdlc_data  = out_q;
  assign hdlc_vld   = vld_q;
  assign dsp_rdata  = rd_v[0];
  assign host_rdata = rd_v[1];
  assign dsp_stat   = stat_v[0];
  assign host_stat  = stat_v[1];
  assign dsp_irq    = irq_v[0];
  assign host_irq   = irq_v[1];

  AST_FWD_NEEDS_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    hdlc_vld |-> $past(chunk_done)); // R2
  AST_NO_FWD_UNPRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done && !primed_q && !bypass && !rx_rst |=> !hdlc_vld); // R5
  AST_STAT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    copy_pend_q && !rx_rst |=> stat_v == 2'b11); // R3
  AST_WR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_q) |-> $past(wr_sel || copy_pend_q || rx_rst)); // R4
endmodule

// File: tb/test_rx_prep_tap.sv
module test_rx_prep_tap;
  logic        clk = 1'b0;
  logic        rst_n, rx_rst, rx_en, cfg_transparent, cfg_owner;
  logic [1:0]  cfg_mode, cfg_chunk;
  logic        line_bit, bit_vld, slot_act;
  logic [31:0] hdlc_data;
  logic        hdlc_vld;
  logic        dsp_we, dsp_clr, dsp_mask, dsp_stat, dsp_irq;
  logic [31:0] dsp_wdata, dsp_rdata;
  logic        host_we, host_clr, host_mask, host_stat, host_irq;
  logic [31:0] host_wdata, host_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q [$];
  logic [31:0] mdl_sr, mdl_wr;
  bit          primed;

  always #2 clk = ~clk;

  rx_prep_tap i_rx_prep_tap (
    .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst), .rx_en(rx_en),
    .cfg_mode(cfg_mode), .cfg_chunk(cfg_chunk), .cfg_transparent(cfg_transparent),
    .cfg_owner(cfg_owner), .line_bit(line_bit), .bit_vld(bit_vld), .slot_act(slot_act),
    .hdlc_data(hdlc_data), .hdlc_vld(hdlc_vld),
    .dsp_we(dsp_we), .dsp_wdata(dsp_wdata), .dsp_clr(dsp_clr), .dsp_mask(dsp_mask),
    .dsp_rdata(dsp_rdata), .dsp_stat(dsp_stat), .dsp_irq(dsp_irq),
    .host_we(host_we), .host_wdata(host_wdata), .host_clr(host_clr), .host_mask(host_mask),
    .host_rdata(host_rdata), .host_stat(host_stat), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && hdlc_vld) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected hdlc word act=%h exp=none", hdlc_data);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (hdlc_data !== e) begin
          n_fail++;
          $display("FAIL R2 hdlc scoreboard act=%h exp=%h", hdlc_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic pulse_rx_rst();
    @(negedge clk); rx_rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rx_rst = 1'b0;
    mdl_sr = '0; mdl_wr = '0; primed = 1'b0;
  endtask

  // driver: pushes the expected forwarded word, then shifts the chunk in MSB first
  task automatic send_chunk(input int nbytes, input logic [31:0] data, input bit gap);
    logic [31:0] snap;
    int nb;
    nb = nbytes * 8;
    snap = mdl_sr;
    for (int i = nb - 1; i >= 0; i--) snap = {snap[30:0], data[i]};
    if (cfg_mode == 2'b00) exp_q.push_back(snap);
    else if (primed) exp_q.push_back(mdl_wr);
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk); bit_vld = 1'b1; line_bit = data[i];
      @(posedge clk);
      if (gap && i != 0) begin
        @(negedge clk); bit_vld = 1'b0; line_bit = ~data[i];
        @(posedge clk);
      end
    end
    @(negedge clk); bit_vld = 1'b0;
    mdl_sr = snap; mdl_wr = snap; primed = 1'b1;
    chk("R2 dsp read copy", dsp_rdata, snap);
    chk("R2 host read copy", host_rdata, snap);
  endtask

  // one 32-bit frame, selected slot on bits 8..15
  task automatic run_frame(input logic [7:0] sb, input int en_at);
    for (int b = 0; b < 32; b++) begin
      @(negedge clk);
      bit_vld  = 1'b1;
      slot_act = (b >= 8 && b < 16);
      line_bit = (b >= 8 && b < 16) ? sb[15-b] : 1'b1;
      if (b == en_at) rx_en = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); bit_vld = 1'b0; slot_act = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rx_rst = 1'b0; rx_en = 1'b0; cfg_mode = 2'b01; cfg_chunk = 2'b00;
    cfg_transparent = 1'b0; cfg_owner = 1'b0; line_bit = 1'b0; bit_vld = 1'b0;
    slot_act = 1'b1; dsp_we = 1'b0; dsp_wdata = '0; dsp_clr = 1'b0; dsp_mask = 1'b0;
    host_we = 1'b0; host_wdata = '0; host_clr = 1'b0; host_mask = 1'b0;
    mdl_sr = '0; mdl_wr = '0; primed = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 hdlc_vld", {31'b0, hdlc_vld}, 0);
    chk("R10 dsp_rdata", dsp_rdata, 0);
    chk("R10 host_rdata", host_rdata, 0);
    chk("R10 stats", {30'b0, dsp_stat, host_stat}, 0);
    chk("R10 irqs", {30'b0, dsp_irq, host_irq}, 0);

    // R1 R5: one-byte chunks, first chunk primes only
    rx_en = 1'b1;
    pulse_rx_rst();
    send_chunk(1, 32'hA5, 1'b0);
    @(negedge clk);
    chk("R5 status on priming chunk", {30'b0, dsp_stat, host_stat}, 32'h3);
    chk("R3 both irqs", {30'b0, dsp_irq, host_irq}, 32'h3);
    send_chunk(1, 32'h3C, 1'b1);
    send_chunk(1, 32'h96, 1'b0);

    // R9 mask and clear
    @(negedge clk); dsp_mask = 1'b1;
    @(negedge clk);
    chk("R9 masked irq", {31'b0, dsp_irq}, 0);
    chk("R9 mask keeps status", {31'b0, dsp_stat}, 1);
    chk("R9 other side irq", {31'b0, host_irq}, 1);
    dsp_clr = 1'b1;
    @(negedge clk); dsp_clr = 1'b0; dsp_mask = 1'b0;
    chk("R9 dsp cleared", {31'b0, dsp_stat}, 0);
    chk("R9 host unaffected", {31'b0, host_stat}, 1);
    @(negedge clk);
    chk("R9 sticky cleared stays", {31'b0, dsp_stat}, 0);
    host_clr = 1'b1;
    @(negedge clk); host_clr = 1'b0;
    chk("R9 host cleared", {31'b0, host_stat}, 0);

    // R4 DSP owner: write on the default-copy edge wins, host write ignored
    cfg_chunk = 2'b01;
    send_chunk(2, 32'h1234, 1'b0);
    dsp_wdata = 32'hDEADBEEF; dsp_we = 1'b1;
    @(negedge clk); dsp_we = 1'b0; mdl_wr = 32'hDEADBEEF;
    chk("R3 status after chunk", {30'b0, dsp_stat, host_stat}, 32'h3);
    host_wdata = 32'h0BAD0BAD; host_we = 1'b1;
    @(negedge clk); host_we = 1'b0;
    send_chunk(2, 32'h5678, 1'b0);

    // R4 host owner with four-byte chunks
    @(negedge clk); cfg_owner = 1'b1; cfg_mode = 2'b11; cfg_chunk = 2'b10;
    send_chunk(4, 32'hCAFEF00D, 1'b0);
    host_wdata = 32'h11112222; host_we = 1'b1;
    dsp_wdata  = 32'h33334444; dsp_we  = 1'b1;
    @(negedge clk); host_we = 1'b0; dsp_we = 1'b0; mdl_wr = 32'h11112222;
    send_chunk(4, 32'h0F0F1E1E, 1'b1);

    // R8 bypass forwards the first chunk at once
    cfg_mode = 2'b00; cfg_chunk = 2'b00; cfg_owner = 1'b0;
    pulse_rx_rst();
    send_chunk(1, 32'h5A, 1'b0);
    @(negedge clk);
    chk("R8 status in bypass", {30'b0, dsp_stat, host_stat}, 32'h3);
    send_chunk(1, 32'hC3, 1'b0);

    // R6 transparent: enable inside the slot waits one frame
    cfg_mode = 2'b01; cfg_transparent = 1'b1; slot_act = 1'b0; rx_en = 1'b0;
    pulse_rx_rst();
    run_frame(8'h81, 10);
    chk("R6 mid-slot bits ignored", dsp_rdata, 0);
    run_frame(8'h6B, -1);
    chk("R6 next-frame slot taken", dsp_rdata, 32'h0000006B);
    exp_q.push_back(32'h0000006B);
    run_frame(8'hE4, -1);
    chk("R1 off-slot bits ignored", host_rdata, 32'h00006BE4);

    // R7 enable before the slot in the same frame
    rx_en = 1'b0;
    pulse_rx_rst();
    run_frame(8'h4D, 3);
    chk("R7 same-frame start", dsp_rdata, 32'h0000004D);

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule